// File: doc/BRIEF.md
# NAND Flash Asynchronous Bus Strobe Sequencer

This block turns single-byte requests into timed cycles on an 8-bit asynchronous external-memory bus with a NAND flash device attached. A request carries a direction, a byte and a kind code. The kind code selects a command cycle (CLE high), an address cycle (ALE high) or a plain data cycle. Each access runs through four phases: setup, strobe, hold and turnaround. The length of each phase comes from a packed 32-bit timing word. Reads and writes have their own setup, strobe and hold values. The turnaround value is shared.

The controller is a five-state machine with these states:
- `ST_IDLE`: waits for a request.
- `ST_SETUP`: chip select low, strobes high.
- `ST_STROBE`: write strobe or read strobe low.
- `ST_HOLD`: chip select still low, strobes high.
- `ST_TURN`: chip select high, the bus rests.

The transitions are:
- start: `ST_IDLE`→`ST_SETUP` when a request is accepted.
- setup_done: `ST_SETUP`→`ST_STROBE`.
- strobe_done: `ST_STROBE`→`ST_HOLD`.
- hold_done: `ST_HOLD`→`ST_TURN`.
- turn_done: `ST_TURN`→`ST_IDLE`.

Each phase except idle lasts its field value plus one clock. The block samples read data at the end of the strobe. It returns that data with a one-cycle valid pulse and signals completion with a one-cycle done pulse. The flash ready/busy line is resynchronised and exposed as a ready status bit.

Top module: `nand_strobe_ctrl`

## Requirements
- R1: After reset, cs_n, we_n and oe_n are high, cle, ale, bus_oe, done and rd_valid are low, and req_ready is high.
- R2: An accepted access drives cs_n low for a setup phase, then a strobe phase, then a hold phase, in that order. During the strobe phase only, we_n (write) or oe_n (read) is low, and the other strobe stays high. Each phase lasts its field value + 1 cycles.
- R3: Timing word fields: write-setup 29:26, write-strobe 25:20, write-hold 19:17, read-setup 16:13, read-strobe 12:7, read-hold 6:4, turnaround 3:2. A write uses only the write fields and a read only the read fields.
- R4: After hold, cs_n is high and req_ready is low for turnaround + 1 cycles, then req_ready rises.
- R5: req_kind 2'b01 is a command: cle high, ale low. 2'b10 is an address: ale high, cle low. 2'b00 and 2'b11 are data: both low. cle/ale are held for every cycle in which cs_n is low and are low otherwise.
- R6: For a write, bus_oe is high and bus_dout equals the request byte in every cycle from setup through hold. bus_oe is low at all other times.
- R7: For a read, the block samples bus_din on the last strobe cycle. It presents that byte on rd_data with rd_valid high for exactly the first hold cycle.
- R8: done is a single-cycle pulse in the first turnaround cycle of every access.
- R9: req_ready is high only in idle. A req_valid raised while req_ready is low starts no access.
- R10: Timing word bits 31, 30, 1 and 0 have no effect on any phase length or output.
- R11: dev_ready follows rb_n_in (1 = device ready) through two flip-flops. A change appears after the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_timing | input | 32 | Packed timing word, sampled at request acceptance |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | 01 command, 10 address, 00/11 data |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Idle, request may be accepted |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | One-cycle read data valid |
| rd_data | output | 8 | Captured read byte |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Read strobe, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| bus_dout | output | 8 | Data bus output value |
| bus_oe | output | 1 | Data bus output enable |
| bus_din | input | 8 | Data bus input value |
| rb_n_in | input | 1 | Flash ready/busy line, 1 = ready |
| dev_ready | output | 1 | Synchronised ready status |

## Verification
The assertions assume the following about inputs:
- req_valid is only meaningful when req_ready is high, and requests raised while busy are dropped.
- The timing word only needs to be stable in the accepting cycle.
- bus_din is only sampled, so nothing is assumed about it.

The stimulus changes inputs on falling edges only. It sweeps setup, strobe, hold and turnaround values together with all four kind codes and both directions. It fills the unused direction's fields and the ignored bits with nonzero junk. It raises one request on purpose while busy to exercise the drop rule.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
    localparam int CNT_W = 6;

    typedef enum logic [1:0] {
        KIND_DATA = 2'b00,
        KIND_CMD  = 2'b01,
        KIND_ADDR = 2'b10,
        KIND_RSVD = 2'b11
    } nsc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_TURN
    } nsc_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] strobe;
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] turn;
    } nsc_timing_t;
endpackage

// File: rtl/nsc_rdy_sync.sv
module nsc_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain_q[i] <= 1'b0;
                else if (i == 0)
                    chain_q[i] <= d_in;
                else
                    chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/nsc_timing_sel.sv
module nsc_timing_sel
    import nsc_pkg::*;
(
    input  logic [31:0]  cfg,
    input  logic         is_write,
    output nsc_timing_t  tim
);
    localparam int WS_LO = 26, WS_W = 4;
    localparam int WT_LO = 20, WT_W = 6;
    localparam int WH_LO = 17, WH_W = 3;
    localparam int RS_LO = 13, RS_W = 4;
    localparam int RT_LO = 7,  RT_W = 6;
    localparam int RH_LO = 4,  RH_W = 3;
    localparam int TA_LO = 2,  TA_W = 2;

    always_comb begin
        tim.turn = CNT_W'(cfg[TA_LO +: TA_W]);
        if (is_write) begin
            tim.setup  = CNT_W'(cfg[WS_LO +: WS_W]);
            tim.strobe = CNT_W'(cfg[WT_LO +: WT_W]);
            tim.hold   = CNT_W'(cfg[WH_LO +: WH_W]);
        end else begin
            tim.setup  = CNT_W'(cfg[RS_LO +: RS_W]);
            tim.strobe = CNT_W'(cfg[RT_LO +: RT_W]);
            tim.hold   = CNT_W'(cfg[RH_LO +: RH_W]);
        end
    end
endmodule

// File: rtl/nsc_phase_timer.sv
module nsc_phase_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/nand_strobe_ctrl.sv
module nand_strobe_ctrl
    import nsc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_timing,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              cs_n,
    output logic              we_n,
    output logic              oe_n,
    output logic              cle,
    output logic              ale,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              rb_n_in,
    output logic              dev_ready
);
    nsc_state_e        state_q, state_d;
    nsc_timing_t       tim_live, tim_q;
    logic              wr_q;
    nsc_kind_e         kind_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q, done_q;
    logic              tmr_load, tmr_last;
    logic [CNT_W-1:0]  tmr_val;
    logic              accept;

    nsc_timing_sel u_sel (
        .cfg      (cfg_timing),
        .is_write (req_write),
        .tim      (tim_live)
    );

    nsc_phase_timer #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    nsc_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rb_n_in),
        .q_out (dev_ready)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    // next state and phase timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                state_d  = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = tim_live.setup;
            end
            ST_SETUP: if (tmr_last) begin
                state_d  = ST_STROBE;
                tmr_load = 1'b1;
                tmr_val  = tim_q.strobe;
            end
            ST_STROBE: if (tmr_last) begin
                state_d  = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = tim_q.hold;
            end
            ST_HOLD: if (tmr_last) begin
                state_d  = ST_TURN;
                tmr_load = 1'b1;
                tmr_val  = tim_q.turn;
            end
            ST_TURN: if (tmr_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and request snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            tim_q    <= '0;
            wr_q     <= 1'b0;
            kind_q   <= KIND_DATA;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            rvalid_q <= (state_q == ST_STROBE) && tmr_last && !wr_q;
            done_q   <= (state_q == ST_HOLD) && tmr_last;
            if (accept) begin
                tim_q   <= tim_live;
                wr_q    <= req_write;
                kind_q  <= nsc_kind_e'(req_kind);
                wdata_q <= req_wdata;
            end
            if ((state_q == ST_STROBE) && tmr_last && !wr_q)
                rdata_q <= bus_din;
        end
    end

    // output decode
    always_comb begin
        logic act;
        act       = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
        req_ready = (state_q == ST_IDLE);
        cs_n      = !act;
        we_n      = !((state_q == ST_STROBE) && wr_q);
        oe_n      = !((state_q == ST_STROBE) && !wr_q);
        cle       = act && (kind_q == KIND_CMD);
        ale       = act && (kind_q == KIND_ADDR);
        bus_oe    = act && wr_q;
        bus_dout  = wdata_q;
        done      = done_q;
        rd_valid  = rvalid_q;
        rd_data   = rdata_q;
    end
endmodule

// File: rtl/nsc_checker.sv
module nsc_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic we_n,
    input logic oe_n,
    input logic cle,
    input logic ale,
    input logic req_ready,
    input logic done,
    input logic rd_valid,
    input logic bus_oe
);
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));
    assert_strobe_in_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !oe_n) |-> !cs_n);
    assert_cle_ale_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    assert_lines_in_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cle || ale) |-> !cs_n);
    assert_bus_oe_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!cs_n && oe_n));
    assert_rdv_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!oe_n) && !cs_n));
    assert_done_after_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n)));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cs_n);
endmodule

bind nand_strobe_ctrl nsc_checker u_nsc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .cle       (cle),
    .ale       (ale),
    .req_ready (req_ready),
    .done      (done),
    .rd_valid  (rd_valid),
    .bus_oe    (bus_oe)
);

// File: tb/tb_nand_strobe_ctrl.sv
module tb_nand_strobe_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_timing = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done, rd_valid;
    logic [7:0]  rd_data;
    logic        cs_n, we_n, oe_n, cle, ale, bus_oe, dev_ready;
    logic [7:0]  bus_dout, bus_din;
    logic        rb_n_in = 1'b0;
    logic [7:0]  rd_pattern = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign bus_din = oe_n ? 8'h00 : rd_pattern;

    nand_strobe_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_timing(cfg_timing),
        .req_valid(req_valid), .req_write(req_write), .req_kind(req_kind),
        .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
        .rd_valid(rd_valid), .rd_data(rd_data), .cs_n(cs_n), .we_n(we_n),
        .oe_n(oe_n), .cle(cle), .ale(ale), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .bus_din(bus_din), .rb_n_in(rb_n_in), .dev_ready(dev_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input bit wr, input int s, input int t,
                                           input int h, input int ta, input bit junk);
        logic [31:0] c;
        c = '0;
        c[3:2] = 2'(ta);
        if (wr) begin
            c[29:26] = 4'(s); c[25:20] = 6'(t); c[19:17] = 3'(h);
            c[16:13] = 4'hF;  c[12:7]  = 6'h3F; c[6:4]   = 3'h7;
        end else begin
            c[16:13] = 4'(s); c[12:7]  = 6'(t); c[6:4]   = 3'(h);
            c[29:26] = 4'hF;  c[25:20] = 6'h3F; c[19:17] = 3'h7;
        end
        if (junk) c = c | 32'hC000_0003; // R10 ignored bits
        return c;
    endfunction

    task automatic do_access(input bit wr, input logic [1:0] kind, input logic [7:0] d,
                             input logic [31:0] c, input int es, input int et,
                             input int eh, input int eta);
        int ns = 0, nt = 0, nh = 0, ntu = 0, cyc = 0;
        int done_n = 0, done_at = -1, rdv_n = 0, rdv_at = -1;
        bit kind_ok = 1, bus_ok = 1, other_ok = 1, rd_ok = 1;
        bit strb;
        @(negedge clk);
        cfg_timing = c; req_write = wr; req_kind = kind; req_wdata = d;
        rd_pattern = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_timing = ~c; // only the accepting cycle matters
        req_wdata = ~d;
        while (!req_ready && cyc < 300) begin
            strb = wr ? !we_n : !oe_n;
            if ((wr ? !oe_n : !we_n)) other_ok = 0;
            if (!cs_n && !strb && nt == 0) ns++;
            else if (!cs_n && strb) nt++;
            else if (!cs_n) nh++;
            else ntu++;
            if (cle !== (!cs_n && kind == 2'b01)) kind_ok = 0;
            if (ale !== (!cs_n && kind == 2'b10)) kind_ok = 0;
            if (bus_oe !== (wr && !cs_n)) bus_ok = 0;
            if (wr && !cs_n && bus_dout !== d) bus_ok = 0;
            if (done) begin done_n++; done_at = cyc; end
            if (rd_valid) begin
                rdv_n++; rdv_at = cyc;
                if (rd_data !== d) rd_ok = 0;
            end
            cyc++;
            @(negedge clk);
        end
        chk(ns == es + 1, "R2 R3 setup length", ns, es + 1);
        chk(nt == et + 1, "R2 R3 strobe length", nt, et + 1);
        chk(nh == eh + 1, "R2 R3 hold length", nh, eh + 1);
        chk(ntu == eta + 1, "R4 turnaround length", ntu, eta + 1);
        chk(other_ok, "R2 other strobe stays high", 0, 1);
        chk(kind_ok, "R5 cle/ale per kind", kind, kind);
        chk(bus_ok, "R6 write bus drive", 0, 1);
        chk(done_n == 1 && done_at == es + et + eh + 3, "R8 done pulse",
            done_at, es + et + eh + 3);
        if (!wr) begin
            chk(rdv_n == 1 && rdv_at == es + et + 2, "R7 rd_valid cycle",
                rdv_at, es + et + 2);
            chk(rd_ok, "R7 rd_data value", rd_data, d);
        end else begin
            chk(rdv_n == 0, "R7 no rd_valid on write", rdv_n, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int idx;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n && we_n && oe_n, "R1 strobes idle high", {cs_n, we_n, oe_n}, 7);
        chk(!cle && !ale && !bus_oe, "R1 lines low", {cle, ale, bus_oe}, 0);
        chk(req_ready && !done && !rd_valid, "R1 ready/pulses", {req_ready, done, rd_valid}, 4);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep: R2 R3 R4 R5 R6 R7 R8 R10
        idx = 0;
        for (int wr = 0; wr < 2; wr++)
            for (int s = 0; s < 3; s++)
                for (int t = 0; t < 3; t++)
                    for (int h = 0; h < 2; h++)
                        for (int ta = 0; ta < 4; ta++) begin
                            do_access(wr[0], 2'(idx), 8'(idx * 37 + 5),
                                      mk_cfg(wr[0], s, t, h, ta, idx[0]), s, t, h, ta);
                            idx++;
                        end

        // larger fields at their top ends (R3)
        do_access(1'b1, 2'b01, 8'hA5, mk_cfg(1'b1, 15, 63, 7, 3, 1'b1), 15, 63, 7, 3);
        do_access(1'b0, 2'b10, 8'h3C, mk_cfg(1'b0, 15, 63, 7, 3, 1'b0), 15, 63, 7, 3);

        // R9: request while busy is dropped
        @(negedge clk);
        cfg_timing = mk_cfg(1'b0, 1, 3, 1, 0, 1'b0);
        req_write = 1'b0; req_kind = 2'b00; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R9 req_ready low when busy", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_kind = 2'b01;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        begin
            bit quiet = 1;
            repeat (4) begin
                @(negedge clk);
                if (!cs_n || !req_ready || cle) quiet = 0;
            end
            chk(quiet, "R9 busy request dropped", 0, 1);
        end

        // R11 ready synchroniser
        @(negedge clk);
        rb_n_in = 1'b1;
        @(negedge clk);
        chk(dev_ready == 1'b0, "R11 ready after one edge", dev_ready, 0);
        @(negedge clk);
        chk(dev_ready == 1'b1, "R11 ready after two edges", dev_ready, 1);
        rb_n_in = 1'b0;
        @(negedge clk);
        chk(dev_ready == 1'b1, "R11 busy after one edge", dev_ready, 1);
        @(negedge clk);
        chk(dev_ready == 1'b0, "R11 busy after two edges", dev_ready, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule